// File: doc/BRIEF.md
# Subroutine Call and Return Stacking Sequencer

This block saves and restores a program counter on a byte-wide memory stack. It handles the stacking part of a subroutine call and of a subroutine return. For a call it takes the address of the call instruction and its addressing mode. It forms the return address, which is the instruction address plus the instruction length. It then writes that address to memory one byte per cycle, least significant byte first, and moves the stack pointer down after each write.

For a return it reads two bytes from the stack, most significant byte first. It moves the stack pointer up before each read and then reloads the program counter. The pull order mirrors the push, so a return undoes a call exactly.

The surrounding core starts a sequence with a one-cycle start request and supplies the current stack pointer. It waits for the done pulse and then takes the updated stack pointer and program counter. The block does not fetch jump targets or decode instructions.

Top module: `stk_call_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_we_o and mem_re_o are low, and sp_o and pc_o are zero.
- R2: A call (op_i = 0) stacks the return address. This is insn_addr_i + 2 when mode_i = 0 (indexed) and insn_addr_i + 3 when mode_i = 1 (extended), modulo 2^16.
- R3: A call writes the low byte of the return address at address SP and the high byte at SP-1. SP is the value of sp_i at the accepted start. The two writes occur in the two cycles after the start edge, and mem_addr_o equals sp_o during each write.
- R4: The stack pointer is decremented after each written byte, so sp_o reads SP-1 during the second write and SP-2 at done.
- R5: A return (op_i = 1) reads the high byte from SP+1 and then the low byte from SP+2, one read per cycle. mem_addr_o equals sp_o+1 during each read, and sp_o reads SP+2 at done.
- R6: After a return, pc_o holds {byte read from SP+1, byte read from SP+2} from the done cycle onward. A call leaves pc_o unchanged.
- R7: done_o is a single-cycle pulse in the cycle after the last transfer. busy_o is high from the cycle after the accepted start through the done cycle.
- R8: A start request is ignored while busy_o is high, including the done cycle. The running sequence completes with its original operands, and no new sequence follows.
- R9: mem_we_o and mem_re_o are never high together. Neither is high outside the transfer cycles, and stack addresses wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| op_i | input | 1 | 0 = call (push), 1 = return (pull) |
| mode_i | input | 1 | Call length select: 0 = two bytes, 1 = three bytes |
| insn_addr_i | input | 16 | Address of the call instruction |
| sp_i | input | 16 | Stack pointer at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Working and final stack pointer |
| pc_o | output | 16 | Program counter reloaded by a return |
| mem_addr_o | output | 16 | Stack memory address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | 8 | Byte read, sampled at the end of the read cycle |

## Verification
Directed calls in both addressing modes separate a two-byte length from a three-byte length. A call at 0xFFFE separates a return address that wraps from one that does not. Pushes from stack pointer 0x0000 and pulls from 0xFFFF check that the stack pointer and memory address wrap in both directions. Random call-then-return pairs over random stack pointers and instruction addresses check that the pull mirrors the push, since any swapped byte order or off-by-one address returns a wrong program counter. Start pulses injected mid-sequence and in the done cycle, carrying different operands, show that a busy sequence is never disturbed or retriggered.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic {
        OP_CALL = 1'b0,
        OP_RET  = 1'b1
    } op_e;

    typedef enum logic {
        MODE_IDX = 1'b0,
        MODE_EXT = 1'b1
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    // Length in bytes of the call instruction for a given addressing mode.
    function automatic int call_len(amode_e m);
        return (m == MODE_EXT) ? 3 : 2;
    endfunction

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
    import stk_seq_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             op_i,
    output logic             accept_o,
    output logic             xfer_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             done_o,
    output op_e              op_o,
    output logic [IDX_W-1:0] idx_o
);

    state_e           st;
    logic [IDX_W-1:0] idx;
    op_e              op_q;

    assign accept_o = start_i && (st == ST_IDLE);
    assign xfer_o   = (st == ST_XFER);
    assign last_o   = xfer_o && (idx == IDX_W'(NBYTES - 1));
    assign busy_o   = (st != ST_IDLE);
    assign done_o   = (st == ST_DONE);
    assign op_o     = op_q;
    assign idx_o    = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            idx  <= '0;
            op_q <= OP_CALL;
        end else begin
            unique case (st)
                ST_IDLE: if (accept_o) begin
                    st   <= ST_XFER;
                    idx  <= '0;
                    op_q <= op_e'(op_i);
                end
                ST_XFER: begin
                    if (last_o) st <= ST_DONE;
                    else        idx <= idx + 1'b1;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stk_sp_unit.sv
module stk_sp_unit
    import stk_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              step_i,
    input  op_e               op_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_up;

    assign sp_up  = sp_q + 1'b1;
    // Push uses the current pointer; pull pre-increments.
    assign addr_o = (op_i == OP_RET) ? sp_up : sp_q;
    assign sp_o   = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (load_i) begin
            sp_q <= sp_i;
        end else if (step_i) begin
            sp_q <= (op_i == OP_RET) ? sp_up : sp_q - 1'b1;
        end
    end

endmodule

// File: rtl/stk_pc_unit.sv
module stk_pc_unit
    import stk_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int NBYTES = ADDR_W / BYTE_W,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] insn_addr_i,
    input  amode_e            mode_i,
    input  logic              rd_i,
    input  logic              last_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [BYTE_W-1:0] wdata_o,
    output logic [ADDR_W-1:0] pc_o
);

    logic [ADDR_W-1:0] ret_q;
    logic [ADDR_W-1:0] stage_q;
    logic [ADDR_W-1:0] stage_nx;
    logic [IDX_W-1:0]  rd_slot;

    // Push order: least significant byte first.
    assign wdata_o = ret_q[idx_i*BYTE_W +: BYTE_W];

    // Pull order: most significant byte first, mirroring the push.
    assign rd_slot = IDX_W'(NBYTES - 1) - idx_i;

    always_comb begin
        stage_nx = stage_q;
        stage_nx[rd_slot*BYTE_W +: BYTE_W] = rdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q   <= '0;
            stage_q <= '0;
            pc_o    <= '0;
        end else begin
            if (load_i) ret_q <= insn_addr_i + ADDR_W'(call_len(mode_i));
            if (rd_i) begin
                stage_q <= stage_nx;
                if (last_i) pc_o <= stage_nx;
            end
        end
    end

endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
    import stk_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] insn_addr_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam int NBYTES = ADDR_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic             accept;
    logic             xfer;
    logic             last;
    op_e              op_cur;
    logic [IDX_W-1:0] idx;

    stk_seq_ctrl #(.NBYTES(NBYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (op_i),
        .accept_o (accept),
        .xfer_o   (xfer),
        .last_o   (last),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .op_o     (op_cur),
        .idx_o    (idx)
    );

    stk_sp_unit #(.ADDR_W(ADDR_W)) u_sp (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .sp_i   (sp_i),
        .step_i (xfer),
        .op_i   (op_cur),
        .sp_o   (sp_o),
        .addr_o (mem_addr_o)
    );

    assign mem_we_o = xfer && (op_cur == OP_CALL);
    assign mem_re_o = xfer && (op_cur == OP_RET);

    stk_pc_unit #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .load_i      (accept),
        .insn_addr_i (insn_addr_i),
        .mode_i      (amode_e'(mode_i)),
        .rd_i        (mem_re_o),
        .last_i      (last),
        .idx_i       (idx),
        .rdata_i     (mem_rdata_i),
        .wdata_o     (mem_wdata_o),
        .pc_o        (pc_o)
    );

endmodule

// File: rtl/stk_call_seq_chk.sv
module stk_call_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_we_o,
    input logic              mem_re_o
);

    // R3
    wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> mem_addr_o == sp_o);

    // R4
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> sp_o == ADDR_W'($past(sp_o) - 1'b1));

    // R5
    rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |-> mem_addr_o == ADDR_W'(sp_o + 1'b1));

    // R5
    pull_inc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |=> sp_o == ADDR_W'($past(sp_o) + 1'b1));

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_re_o |=> $stable(pc_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o && !done_o);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we_o, mem_re_o, done_o}));

    // R9
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_we_o && !mem_re_o);

endmodule

bind stk_call_seq stk_call_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sp_o       (sp_o),
    .pc_o       (pc_o),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o)
);

// File: tb/stk_call_seq_test.sv
`timescale 1ns/1ps
module stk_call_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [15:0] insn_addr_i = '0;
    logic [15:0] sp_i = '0;
    logic        busy_o, done_o, mem_we_o, mem_re_o;
    logic [15:0] sp_o, pc_o, mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;

    logic [7:0] mem [0:255];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    stk_call_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
        .insn_addr_i(insn_addr_i), .sp_i(sp_i), .busy_o(busy_o), .done_o(done_o),
        .sp_o(sp_o), .pc_o(pc_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i)
    );

    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

    function automatic logic [15:0] exp_ret(logic [15:0] ia, logic m);
        return ia + (m ? 16'd3 : 16'd2);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one sequence. Optionally injects conflicting start pulses while busy.
    task automatic run_seq(logic op, logic m, logic [15:0] ia, logic [15:0] sp,
                           bit inject, output logic [15:0] pc_seen);
        logic [15:0] ret, pc_before;
        ret = exp_ret(ia, m);
        pc_before = pc_o;
        @(negedge clk);
        start_i = 1; op_i = op; mode_i = m; insn_addr_i = ia; sp_i = sp;
        @(negedge clk);            // first transfer cycle
        start_i = 0;
        chk(busy_o && !done_o, "R7 busy after start", {busy_o, done_o}, 2'b10);
        if (op == 1'b0) begin
            chk(mem_we_o && !mem_re_o && mem_addr_o == sp && mem_wdata_o == ret[7:0],
                "R3 first push", {mem_addr_o, mem_wdata_o}, {sp, ret[7:0]});
        end else begin
            chk(mem_re_o && !mem_we_o && mem_addr_o == sp + 16'd1,
                "R5 first pull", mem_addr_o, sp + 16'd1);
        end
        if (inject) begin
            start_i = 1; op_i = ~op; mode_i = ~m; insn_addr_i = ~ia; sp_i = ~sp;
        end
        @(negedge clk);            // second transfer cycle
        if (op == 1'b0) begin
            chk(mem_we_o && mem_addr_o == sp - 16'd1 && mem_wdata_o == ret[15:8],
                "R3 second push", {mem_addr_o, mem_wdata_o}, {sp - 16'd1, ret[15:8]});
            chk(sp_o == sp - 16'd1, "R4 sp after first push", sp_o, sp - 16'd1);
        end else begin
            chk(mem_re_o && mem_addr_o == sp + 16'd2, "R5 second pull", mem_addr_o, sp + 16'd2);
            chk(sp_o == sp + 16'd1, "R5 sp after first pull", sp_o, sp + 16'd1);
        end
        @(negedge clk);            // done cycle
        chk(done_o && busy_o && !mem_we_o && !mem_re_o, "R7 done pulse",
            {done_o, busy_o, mem_we_o, mem_re_o}, 4'b1100);
        if (op == 1'b0) begin
            chk(sp_o == sp - 16'd2, "R4 final sp", sp_o, sp - 16'd2);
            chk(pc_o == pc_before, "R6 call keeps pc", pc_o, pc_before);
            chk(mem[sp[7:0]] == ret[7:0] && mem[8'(sp[7:0] - 8'd1)] == ret[15:8],
                "R2 stacked return address",
                {mem[8'(sp[7:0] - 8'd1)], mem[sp[7:0]]}, ret);
        end else begin
            chk(sp_o == sp + 16'd2, "R5 final sp", sp_o, sp + 16'd2);
        end
        pc_seen = pc_o;
        @(negedge clk);
        start_i = 0;
        chk(!done_o && !busy_o && !mem_we_o && !mem_re_o, "R8 no retrigger / R7 end",
            {done_o, busy_o, mem_we_o, mem_re_o}, 4'b0000);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] pc, sp, ia;
        logic m;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !mem_we_o && !mem_re_o && sp_o == 0 && pc_o == 0,
            "R1 reset", {busy_o, done_o, mem_we_o, mem_re_o, sp_o, pc_o}, 0);
        rst = 0;
        @(negedge clk);

        // R2 indexed call then return
        run_seq(1'b0, 1'b0, 16'h1234, 16'h0080, 0, pc);
        run_seq(1'b1, 1'b0, 16'h0000, 16'h007E, 0, pc);
        chk(pc == 16'h1236, "R6 return pc indexed", pc, 16'h1236);

        // R2 extended call with address wrap, SP wrap at 0x0000
        run_seq(1'b0, 1'b1, 16'hFFFE, 16'h0000, 0, pc);
        run_seq(1'b1, 1'b0, 16'h0000, 16'hFFFE, 0, pc);
        chk(pc == 16'h0001, "R9 wrap return pc", pc, 16'h0001);

        // R5 pull from 0xFFFF wraps upward; R6 byte order from preloaded memory
        mem[8'h00] = 8'hAB; mem[8'h01] = 8'hCD;
        run_seq(1'b1, 1'b0, 16'h0000, 16'hFFFF, 0, pc);
        chk(pc == 16'hABCD, "R6 high byte first", pc, 16'hABCD);

        // R8 starts injected mid-sequence and in the done cycle
        run_seq(1'b0, 1'b1, 16'h4000, 16'h0040, 1, pc);
        run_seq(1'b1, 1'b0, 16'h0000, 16'h003E, 1, pc);
        chk(pc == 16'h4003, "R8 operands unchanged", pc, 16'h4003);

        // Random round trips
        for (int k = 0; k < 40; k++) begin
            sp = 16'($urandom);
            ia = 16'($urandom);
            m  = 1'($urandom);
            run_seq(1'b0, m, ia, sp, k[0], pc);
            run_seq(1'b1, 1'($urandom), 16'($urandom), sp - 16'd2, k[1], pc);
            chk(pc == exp_ret(ia, m), "R2 random round trip", pc, exp_ret(ia, m));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule